// File: doc/BRIEF.md
# Preset Delay Counter

This block produces a programmable delay after a start trigger. The delay is measured by counting steps. In time mode a step is one pulse of a periodic tick enable, so with a 10 MHz tick each step is 100 ns. In events mode a step is one external event pulse. The delay setting is a multi-decade BCD number. When a trigger is accepted, the nines complement of that number is loaded into a BCD up-counter. The delay is over once every decade of the counter reads nine.

While the delay runs, a level output stays high. When the delay ends, that level falls and a one-clock trigger pulse is issued on the same edge. A holdoff level then lasts for a fixed number of clocks, and start triggers are refused during it. In events mode the trigger opens the interval, but counting waits for a separate arming pulse, so the event that started the delay is not counted. An echo option counts only every second tick in time mode. This doubles the generated delay against the setting, so the setting reads as the one-way time of a round trip.

Top module: `preset_delay_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `delay_interval`, `delayed_trig` and `holdoff` and returns the block to idle, even in the middle of a delay.
- R2: A `start_trig` seen while idle with `holdoff` low is accepted. `delay_interval` goes high on that edge. The BCD setting (4 bits per decade, decade 0 in bits [3:0]), `events_mode` and `echo_mode` are latched on that edge.
- R3: In time mode with echo off, each `tick_en` pulse during the delay is one step. After the N-th step, `delay_interval` falls one clock later. A setting of 0 ends the delay one clock after acceptance.
- R4: `delay_interval` falls only together with `delayed_trig`. `delayed_trig` is high for exactly one clock per delay.
- R5: In events mode, `event_in` pulses are not counted before a pulse on `events_arm`. An event pulse in the same cycle as the arming pulse is not counted either. Event pulses in later cycles are counted one step each.
- R6: With echo on in time mode, only every second tick is a step, starting with the second tick after acceptance. A setting N therefore spans 2N ticks.
- R7: `holdoff` is high for exactly HOLD_CYC clocks, starting on the edge where the delay ends. A `start_trig` during holdoff, or during a running delay, is ignored.
- R8: Event pulses that arrive while idle or in holdoff have no effect. The next events-mode delay still needs the full set count after arming.
- R9: The all-nines setting (10^DIGITS - 1) runs for that many steps. The counter's start value is then 0 in every decade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Periodic time-base tick, one clock wide |
| event_in | input | 1 | Event pulse to count, one clock wide |
| events_mode | input | 1 | 1 = count events, 0 = count ticks |
| echo_mode | input | 1 | 1 = halve the tick rate in time mode |
| start_trig | input | 1 | Start trigger pulse |
| events_arm | input | 1 | Arms event counting in events mode |
| setting_bcd | input | 4*DIGITS | BCD delay setting |
| delay_interval | output | 1 | High for the duration of the delay |
| delayed_trig | output | 1 | One-clock pulse at the end of the delay |
| holdoff | output | 1 | High while new triggers are refused |

## Verification
The bench builds the block with DIGITS=3 and HOLD_CYC=3. With three decades, the all-nines setting of 999 and the zero setting both fit in a short run. The decade carry chain is then exercised across every digit. Because the holdoff window is short, the bench can place triggers and events exactly inside it and exactly at its end.

// File: rtl/preset_delay_counter.sv
module preset_delay_counter #(
  parameter int DIGITS   = 7,
  parameter int HOLD_CYC = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                event_in,
  input  logic                events_mode,
  input  logic                echo_mode,
  input  logic                start_trig,
  input  logic                events_arm,
  input  logic [4*DIGITS-1:0] setting_bcd,
  output logic                delay_interval,
  output logic                delayed_trig,
  output logic                holdoff
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int CW = 4 * DIGITS;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} state_t;

  state_t        state;
  logic          ev_sel, echo_sel, phase;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] cnt, cnt_inc, cnt_load;
  logic [DIGITS:0]   carry;
  logic [DIGITS-1:0] is9;

  wire all9   = &is9;
  wire accept = (state == S_IDLE) && (hold_cnt == '0) && start_trig;
  wire step   = ev_sel ? event_in : (tick_en && (!echo_sel || phase));

  assign carry[0] = step;
  assign holdoff  = (hold_cnt != '0);

  for (genvar g = 0; g < DIGITS; g++) begin : g_dec
    assign is9[g]          = (cnt[4*g +: 4] == 4'd9);
    assign carry[g+1]      = carry[g] && is9[g];
    assign cnt_inc[4*g +: 4] = !carry[g] ? cnt[4*g +: 4] :
                               is9[g]    ? 4'd0 : cnt[4*g +: 4] + 4'd1;
    assign cnt_load[4*g +: 4] = 4'd9 - setting_bcd[4*g +: 4];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= S_IDLE;
      cnt            <= '0;
      ev_sel         <= 1'b0;
      echo_sel       <= 1'b0;
      phase          <= 1'b0;
      hold_cnt       <= '0;
      delay_interval <= 1'b0;
      delayed_trig   <= 1'b0;
    end else begin
      delayed_trig <= 1'b0;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          cnt            <= cnt_load;
          ev_sel         <= events_mode;
          echo_sel       <= echo_mode;
          phase          <= 1'b0;
          delay_interval <= 1'b1;
          state          <= events_mode ? S_ARM : S_RUN;
        end
        S_ARM: if (events_arm) state <= S_RUN;
        S_RUN: if (all9) begin
          state          <= S_IDLE;
          delay_interval <= 1'b0;
          delayed_trig   <= 1'b1;
          hold_cnt       <= HW'(HOLD_CYC);
        end else begin
          cnt <= cnt_inc;
          if (tick_en && echo_sel && !ev_sel) phase <= !phase;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/preset_delay_counter_chk.sv
module preset_delay_counter_chk (
  input logic clk,
  input logic rst,
  input logic delay_interval,
  input logic delayed_trig,
  input logic holdoff
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !delay_interval && !delayed_trig && !holdoff); // R1
  AST_PULSE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    delayed_trig |-> !delay_interval && $past(delay_interval)); // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    delayed_trig |=> !delayed_trig); // R4
  AST_FALL_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(delay_interval) && !$past(rst) |-> delayed_trig); // R4
  AST_HOLD_FROM_END: assert property (@(posedge clk) disable iff (rst)
    delayed_trig |-> holdoff); // R7
  AST_NO_START_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    holdoff && !delay_interval |=> !delay_interval); // R7
endmodule

bind preset_delay_counter preset_delay_counter_chk u_chk (
  .clk(clk), .rst(rst), .delay_interval(delay_interval),
  .delayed_trig(delayed_trig), .holdoff(holdoff)
);

// File: tb/tb_preset_delay_counter.sv
module tb_preset_delay_counter;
  localparam int DIGITS = 3;
  localparam int HOLD   = 3;

  logic clk = 0, rst = 1;
  logic tick_en = 0, event_in = 0, events_mode = 0, echo_mode = 0;
  logic start_trig = 0, events_arm = 0;
  logic [4*DIGITS-1:0] setting_bcd = '0;
  logic delay_interval, delayed_trig, holdoff;

  int checks = 0, failures = 0, cyc = 0;
  bit ev_on = 0, started = 0;
  string cur_req = "R1";
  int trig_seen = 0, trig_exp = 0;

  // reference model state
  int m_state = 0, m_rem = 0, m_hold = 0;
  bit m_ev = 0, m_echo = 0, m_phase = 0;
  bit e_act = 0, e_trg = 0;

  always #2.5 clk = ~clk;

  preset_delay_counter #(.DIGITS(DIGITS), .HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .event_in(event_in),
    .events_mode(events_mode), .echo_mode(echo_mode), .start_trig(start_trig),
    .events_arm(events_arm), .setting_bcd(setting_bcd),
    .delay_interval(delay_interval), .delayed_trig(delayed_trig), .holdoff(holdoff));

  function automatic logic [4*DIGITS-1:0] to_bcd(int n);
    logic [4*DIGITS-1:0] r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  function automatic int from_bcd(logic [4*DIGITS-1:0] b);
    int r = 0;
    for (int i = DIGITS - 1; i >= 0; i--) r = r * 10 + int'(b[4*i +: 4]);
    return r;
  endfunction

  always @(posedge clk) begin
    int h0;
    bit stp;
    started = 1;
    if (rst) begin
      m_state = 0; m_rem = 0; m_hold = 0; m_phase = 0; e_act = 0; e_trg = 0;
    end else begin
      e_trg = 0;
      h0 = m_hold;
      if (m_hold > 0) m_hold--;
      case (m_state)
        0: if (start_trig && h0 == 0) begin
          m_rem = from_bcd(setting_bcd); m_ev = events_mode; m_echo = echo_mode;
          m_phase = 0; e_act = 1; m_state = events_mode ? 1 : 2;
          trig_exp++;
        end
        1: if (events_arm) m_state = 2;
        default: if (m_rem == 0) begin
          m_state = 0; e_act = 0; e_trg = 1; m_hold = HOLD;
        end else begin
          stp = m_ev ? event_in : (tick_en && (!m_echo || m_phase));
          if (stp) m_rem--;
          if (!m_ev && m_echo && tick_en) m_phase = !m_phase;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    tick_en <= (cyc % 3 == 0);
    event_in <= ev_on && (cyc % 4 != 1);
    if (started) begin
      if (delayed_trig) trig_seen++;
      checks++;
      if (delay_interval !== e_act) begin
        failures++;
        $display("FAIL %s delay_interval actual=%b expected=%b t=%0t", cur_req, delay_interval, e_act, $time);
      end
      checks++;
      if (delayed_trig !== e_trg) begin
        failures++;
        $display("FAIL R4 delayed_trig actual=%b expected=%b t=%0t", delayed_trig, e_trg, $time);
      end
      checks++;
      if (holdoff !== (m_hold != 0)) begin
        failures++;
        $display("FAIL R7 holdoff actual=%b expected=%b t=%0t", holdoff, (m_hold != 0), $time);
      end
    end
  end

  task automatic pulse_trig();
    @(negedge clk) start_trig = 1;
    @(negedge clk) start_trig = 0;
  endtask

  task automatic pulse_arm();
    @(negedge clk) events_arm = 1;
    @(negedge clk) events_arm = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (delay_interval || holdoff);
  endtask

  task automatic run_time(int n, bit echo);
    @(negedge clk);
    setting_bcd = to_bcd(n); events_mode = 0; echo_mode = echo;
    pulse_trig();
    wait_idle();
  endtask

  task automatic check_clear(string tag);
    checks++;
    if (delay_interval !== 0 || delayed_trig !== 0 || holdoff !== 0) begin
      failures++;
      $display("FAIL %s after reset actual=%b%b%b expected=000", tag, delay_interval, delayed_trig, holdoff);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_clear("R1");

    cur_req = "R3"; run_time(5, 0); run_time(0, 0); run_time(37, 0);
    cur_req = "R2"; run_time(12, 0);
    cur_req = "R6"; run_time(4, 1); run_time(1, 1);

    cur_req = "R5";
    setting_bcd = to_bcd(6); events_mode = 1; echo_mode = 0;
    pulse_trig();
    ev_on = 1;
    repeat (12) @(negedge clk);
    pulse_arm();
    wait_idle();
    ev_on = 0;

    cur_req = "R7";
    setting_bcd = to_bcd(3); events_mode = 0;
    pulse_trig();
    repeat (4) @(negedge clk);
    pulse_trig();
    do @(negedge clk); while (!delayed_trig);
    start_trig = 1;
    repeat (HOLD) @(negedge clk);
    start_trig = 0;
    wait_idle();

    cur_req = "R8";
    ev_on = 1;
    setting_bcd = to_bcd(9); events_mode = 1;
    pulse_trig();
    repeat (5) @(negedge clk);
    pulse_arm();
    do @(negedge clk); while (!delayed_trig);
    repeat (HOLD + 4) @(negedge clk);
    pulse_trig();
    pulse_arm();
    wait_idle();
    ev_on = 0;

    cur_req = "R9"; run_time(999, 0);

    cur_req = "R1";
    setting_bcd = to_bcd(50); events_mode = 0; echo_mode = 0;
    pulse_trig();
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk) rst = 0;
    check_clear("R1");
    run_time(2, 0);

    checks++;
    if (trig_seen != trig_exp - 1) begin
      failures++;
      $display("FAIL R4 end pulses actual=%0d expected=%0d", trig_seen, trig_exp - 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule